// File: doc/BRIEF.md
# Transactional checkpoint and rollback controller

This block sits beside a six-stage in-order pipeline (fetch, schedule, decode, execute, memory, writeback). It looks for three marker instructions as they pass through decode. Each marker is a SETHI that writes the hardwired-zero register, and each one opens, closes or undoes a register-state checkpoint. The block follows every decoded instruction through execute, memory and writeback. It acts on a marker only when the marker retires, so every older instruction has already updated processor state.

When a checkpoint retires, the block takes a snapshot and saves the restart PC, which is the address just past the marker's delay slots. It then counts the instructions that retire inside the open transaction. A commit marker closes the transaction. So does a forced commit once the transaction reaches its configured length. A rollback marker sends the front end back to the saved restart PC and flushes the fetch, schedule and decode stages. The register-file copy, the caches and the exception handling live outside this block and are driven by its strobes.

Top module: `txn_ckpt_ctrl`

## Requirements
- R1: After reset, and while reset is held, the following are all low: `txn_active`, `snap_stb`, `commit_stb`, `rollback_stb`, `flush_front` and `redir_pc`. At most one strobe is high in any cycle.
- R2: A decoded word is a marker only when bits [31:30]=00, bits [29:25]=0 and bits [24:22]=100, and bits [21:0] are 3 (checkpoint), 2 (commit) or 1 (rollback). A SETHI with any other immediate, or with a nonzero destination, is an ordinary instruction.
- R3: A marker accepted in decode on an advancing cycle acts in the cycle in which it sits in writeback with `pipe_adv` high. That is the third advancing cycle after it was accepted.
- R4: A retiring checkpoint marker pulses `snap_stb` for one cycle, sets `txn_active`, saves marker PC + 4*(CKPT_SLOTS+1) as the restart PC, and clears the length count.
- R5: A retiring commit marker while `txn_active` is set pulses `commit_stb` for one cycle and clears `txn_active` from the next cycle.
- R6: A commit or rollback marker that retires while `txn_active` is clear produces no strobe and no flush.
- R7: A retiring rollback marker while `txn_active` is set pulses `rollback_stb`, drives `redir_pc` to the restart PC and drives `flush_front` to 3'b111, all in the same cycle. `txn_active` stays set and the length count is cleared.
- R8: While `txn_active` is set, each valid non-marker instruction that retires is counted; bubbles are not counted. When the MAX_LEN-th counted instruction retires, `commit_stb` pulses in that cycle and `txn_active` clears.
- R9: With `pipe_adv` low, nothing moves and no strobe is issued. A marker held in writeback acts exactly once, in the first cycle in which `pipe_adv` is high.
- R10: The decode-stage instruction presented in the rollback cycle is discarded, so a marker presented there never acts.
- R11: A checkpoint marker that retires while `txn_active` is already set replaces the restart PC with the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_adv | input | 1 | Pipeline advances this cycle |
| dec_valid | input | 1 | Decode stage holds a valid instruction |
| dec_insn | input | 32 | Instruction word in decode |
| dec_pc | input | PCW | PC of the instruction in decode |
| snap_stb | output | 1 | Take register snapshot |
| commit_stb | output | 1 | Commit the open transaction (marker or forced) |
| rollback_stb | output | 1 | Restore snapshot |
| redir_pc | output | PCW | Restart PC during rollback, zero otherwise |
| flush_front | output | 3 | Flush for decode, schedule and fetch |
| txn_active | output | 1 | A checkpoint is open |

## Verification
The bench times every strobe against the writeback position of its marker. A design that acted at decode, or that was off by one stage, would pulse early or late and is caught. Stall cycles are placed while a marker sits in writeback. A design that fired while stalled, or fired twice, would show a strobe in a stall cycle or an extra strobe.

The length limit is tested with a bubble inside the window, and again after a rollback. A design that counted bubbles, or that did not clear the count on rollback, would force its commit too early. A checkpoint marker is placed in decode during the rollback cycle, and misleading SETHI encodings are sent with no transaction open. A design that kept the flushed word, or that decoded markers too loosely, would produce an extra snapshot.

// File: rtl/txn_ckpt_pkg.sv
package txn_ckpt_pkg;
   typedef enum logic [1:0] {
      MK_NONE = 2'd0,
      MK_CKPT = 2'd1,
      MK_CMT  = 2'd2,
      MK_RBK  = 2'd3
   } mark_e;

   localparam logic [1:0]  OP_FMT2   = 2'b00;
   localparam logic [2:0]  OP2_SETHI = 3'b100;
   localparam logic [21:0] IMM_CKPT  = 22'h3;
   localparam logic [21:0] IMM_CMT   = 22'h2;
   localparam logic [21:0] IMM_RBK   = 22'h1;
   localparam int          INSN_W    = 32;
endpackage

// File: rtl/txn_mark_dec.sv
module txn_mark_dec
   import txn_ckpt_pkg::*;
(
   input  logic              valid,
   input  logic [INSN_W-1:0] insn,
   output mark_e             mark
);
   logic        is_zero_sethi;
   logic [21:0] imm;

   assign imm           = insn[21:0];
   assign is_zero_sethi = valid && (insn[31:30] == OP_FMT2) &&
                          (insn[29:25] == 5'd0) && (insn[24:22] == OP2_SETHI);

   always_comb begin
      mark = MK_NONE;
      if (is_zero_sethi) begin
         unique case (imm)
            IMM_CKPT: mark = MK_CKPT;
            IMM_CMT:  mark = MK_CMT;
            IMM_RBK:  mark = MK_RBK;
            default:  mark = MK_NONE;
         endcase
      end
   end
endmodule

// File: rtl/txn_slot_pipe.sv
module txn_slot_pipe
   import txn_ckpt_pkg::*;
#(
   parameter int PCW   = 32,
   parameter int DEPTH = 3
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           adv,
   input  logic           drop,
   input  logic           in_vld,
   input  mark_e          in_mark,
   input  logic [PCW-1:0] in_pc,
   output logic           out_vld,
   output mark_e          out_mark,
   output logic [PCW-1:0] out_pc
);
   typedef struct packed {
      logic           vld;
      mark_e          mark;
      logic [PCW-1:0] pc;
   } slot_t;

   slot_t head;
   assign head = '{vld: in_vld && !drop, mark: (drop ? MK_NONE : in_mark), pc: in_pc};

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      slot_t q;
      slot_t nxt;
      if (g == 0) begin : g_head
         assign nxt = head;
      end else begin : g_body
         assign nxt = g_stage[g-1].q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '0;
         else if (adv) q <= nxt;
      end
   end

   assign out_vld  = g_stage[DEPTH-1].q.vld;
   assign out_mark = g_stage[DEPTH-1].q.mark;
   assign out_pc   = g_stage[DEPTH-1].q.pc;

   // R9
   hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(out_vld) && $stable(out_mark) && $stable(out_pc));
endmodule

// File: rtl/txn_state.sv
module txn_state
   import txn_ckpt_pkg::*;
#(
   parameter int PCW        = 32,
   parameter int MAX_LEN    = 64,
   parameter int CKPT_SLOTS = 3,
   parameter int FLUSH_W    = 3
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv,
   input  logic               w_vld,
   input  mark_e              w_mark,
   input  logic [PCW-1:0]     w_pc,
   output logic               snap_stb,
   output logic               commit_stb,
   output logic               rollback_stb,
   output logic [PCW-1:0]     redir_pc,
   output logic [FLUSH_W-1:0] flush_front,
   output logic               active
);
   localparam int             CW      = $clog2(MAX_LEN + 1);
   localparam logic [PCW-1:0] RST_OFF = PCW'(4 * (CKPT_SLOTS + 1));
   localparam logic [CW-1:0]  LAST    = CW'(MAX_LEN - 1);

   logic [CW-1:0]  cnt;
   logic [PCW-1:0] restart_pc;
   logic           retire, ck_ev, cm_ev, rb_ev, counted, force_ev;

   assign retire   = w_vld && adv;
   assign ck_ev    = retire && (w_mark == MK_CKPT);
   assign cm_ev    = retire && (w_mark == MK_CMT) && active;
   assign rb_ev    = retire && (w_mark == MK_RBK) && active;
   assign counted  = retire && (w_mark == MK_NONE) && active;
   assign force_ev = counted && (cnt == LAST);

   assign snap_stb     = ck_ev;
   assign commit_stb   = cm_ev || force_ev;
   assign rollback_stb = rb_ev;
   assign redir_pc     = rb_ev ? restart_pc : '0;
   assign flush_front  = {FLUSH_W{rb_ev}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active     <= 1'b0;
         cnt        <= '0;
         restart_pc <= '0;
      end else if (ck_ev) begin
         active     <= 1'b1;
         cnt        <= '0;
         restart_pc <= w_pc + RST_OFF;
      end else if (commit_stb) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (rb_ev) begin
         cnt <= '0;
      end else if (counted) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R1
   one_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({snap_stb, commit_stb, rollback_stb}));
   // R4
   snap_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_stb |=> active && (restart_pc == $past(w_pc) + RST_OFF));
   // R5
   cmt_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_stb |=> !active);
   // R7
   rb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rollback_stb |=> active && (cnt == '0));
   // R8
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(MAX_LEN));
endmodule

// File: rtl/txn_ckpt_ctrl.sv
module txn_ckpt_ctrl
   import txn_ckpt_pkg::*;
#(
   parameter int PCW        = 32,
   parameter int MAX_LEN    = 64,
   parameter int CKPT_SLOTS = 3,
   parameter int BACK_DEPTH = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_adv,
   input  logic              dec_valid,
   input  logic [INSN_W-1:0] dec_insn,
   input  logic [PCW-1:0]    dec_pc,
   output logic              snap_stb,
   output logic              commit_stb,
   output logic              rollback_stb,
   output logic [PCW-1:0]    redir_pc,
   output logic [2:0]        flush_front,
   output logic              txn_active
);
   if (MAX_LEN < 2) begin : g_bad_len
      $error("MAX_LEN must be at least 2");
   end
   if (BACK_DEPTH < 1) begin : g_bad_depth
      $error("BACK_DEPTH must be at least 1");
   end
   if (PCW < 8) begin : g_bad_pcw
      $error("PCW too narrow");
   end

   mark_e          d_mark, w_mark;
   logic           w_vld;
   logic [PCW-1:0] w_pc;

   txn_mark_dec u_dec (
      .valid (dec_valid),
      .insn  (dec_insn),
      .mark  (d_mark)
   );

   txn_slot_pipe #(.PCW(PCW), .DEPTH(BACK_DEPTH)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (pipe_adv),
      .drop     (rollback_stb),
      .in_vld   (dec_valid),
      .in_mark  (d_mark),
      .in_pc    (dec_pc),
      .out_vld  (w_vld),
      .out_mark (w_mark),
      .out_pc   (w_pc)
   );

   txn_state #(.PCW(PCW), .MAX_LEN(MAX_LEN), .CKPT_SLOTS(CKPT_SLOTS), .FLUSH_W(3)) u_state (
      .clk          (clk),
      .rst_n        (rst_n),
      .adv          (pipe_adv),
      .w_vld        (w_vld),
      .w_mark       (w_mark),
      .w_pc         (w_pc),
      .snap_stb     (snap_stb),
      .commit_stb   (commit_stb),
      .rollback_stb (rollback_stb),
      .redir_pc     (redir_pc),
      .flush_front  (flush_front),
      .active       (txn_active)
   );

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_active |-> !rollback_stb && (flush_front == 3'b000));
   // R7
   flush_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_front != 3'b000) |-> rollback_stb && (flush_front == 3'b111));
endmodule

// File: tb/txn_ckpt_ctrl_tb_top.sv
module txn_ckpt_ctrl_tb_top;
   localparam int ML = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pipe_adv = 1'b0, dec_valid = 1'b0;
   logic [31:0] dec_insn = '0, dec_pc = '0;
   logic        snap_stb, commit_stb, rollback_stb, txn_active;
   logic [31:0] redir_pc;
   logic [2:0]  flush_front;

   int n_chk = 0, n_fail = 0;
   logic        s_snap, s_cmt, s_rb, s_act;
   logic [31:0] s_redir;
   logic [2:0]  s_flush;

   always #4 clk = ~clk;

   txn_ckpt_ctrl #(.PCW(32), .MAX_LEN(ML), .CKPT_SLOTS(3), .BACK_DEPTH(3)) dut_i (
      .clk(clk), .rst_n(rst_n), .pipe_adv(pipe_adv), .dec_valid(dec_valid),
      .dec_insn(dec_insn), .dec_pc(dec_pc), .snap_stb(snap_stb),
      .commit_stb(commit_stb), .rollback_stb(rollback_stb), .redir_pc(redir_pc),
      .flush_front(flush_front), .txn_active(txn_active));

   function automatic logic [31:0] sethi(input logic [4:0] rd, input logic [21:0] imm);
      return {2'b00, rd, 3'b100, imm};
   endfunction

   localparam logic [31:0] NOP  = 32'h0100_0000;
   localparam logic [31:0] BRBK = 32'h30BF_FFFF;

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic cyc(input logic v, input logic [31:0] ins, input logic [31:0] p, input logic a);
      @(negedge clk);
      dec_valid = v; dec_insn = ins; dec_pc = p; pipe_adv = a;
      #1;
      s_snap = snap_stb; s_cmt = commit_stb; s_rb = rollback_stb;
      s_act = txn_active; s_redir = redir_pc; s_flush = flush_front;
   endtask

   task automatic nop(input logic [31:0] p);
      cyc(1'b1, NOP, p, 1'b1);
   endtask

   task automatic close_txn(input logic [31:0] p);
      cyc(1'b1, sethi(5'd0, 22'h2), p, 1'b1);
      nop(p + 4); nop(p + 8); nop(p + 12);
      nop(p + 16);
      chk("R5", "closed", {31'd0, s_act}, 32'd0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "strobes in reset", {28'd0, snap_stb, commit_stb, rollback_stb, txn_active}, 32'd0);
      chk("R1", "flush in reset", {29'd0, flush_front}, 32'd0);
      chk("R1", "redir in reset", redir_pc, 32'd0);
      rst_n = 1'b1;
      nop(32'h0);
      chk("R1", "active after reset", {31'd0, s_act}, 32'd0);
   endtask

   task automatic t_ckpt_commit();
      cyc(1'b1, sethi(5'd0, 22'h3), 32'h100, 1'b1);
      nop(32'h104); chk("R3", "no early snap 1", {31'd0, s_snap}, 32'd0);
      nop(32'h108); chk("R3", "no early snap 2", {31'd0, s_snap}, 32'd0);
      nop(32'h10c); chk("R3", "snap at writeback", {31'd0, s_snap}, 32'd1);
      chk("R4", "active not yet", {31'd0, s_act}, 32'd0);
      nop(32'h110); chk("R4", "snap one cycle", {31'd0, s_snap}, 32'd0);
      chk("R4", "active set", {31'd0, s_act}, 32'd1);
      cyc(1'b1, sethi(5'd0, 22'h2), 32'h114, 1'b1);
      nop(32'h118); nop(32'h11c);
      chk("R5", "no early commit", {31'd0, s_cmt}, 32'd0);
      nop(32'h120); chk("R5", "commit pulse", {31'd0, s_cmt}, 32'd1);
      nop(32'h124); chk("R5", "commit one cycle", {31'd0, s_cmt}, 32'd0);
      chk("R5", "active cleared", {31'd0, s_act}, 32'd0);
   endtask

   task automatic t_ignore();
      cyc(1'b1, sethi(5'd0, 22'h2), 32'h140, 1'b1);
      cyc(1'b1, sethi(5'd0, 22'h1), 32'h144, 1'b1);
      cyc(1'b1, sethi(5'd5, 22'h3), 32'h148, 1'b1);
      cyc(1'b1, sethi(5'd0, 22'h4), 32'h14c, 1'b1);
      cyc(1'b1, BRBK, 32'h150, 1'b1);
      for (int i = 0; i < 6; i++) begin
         nop(32'h154 + 4 * i);
         chk("R6 R2", "idle outputs", {25'd0, s_snap, s_cmt, s_rb, s_act, s_flush}, 32'd0);
      end
   endtask

   task automatic t_rollback();
      cyc(1'b1, sethi(5'd0, 22'h3), 32'h200, 1'b1);
      nop(32'h204); nop(32'h208); nop(32'h20c);
      cyc(1'b1, sethi(5'd0, 22'h3), 32'h300, 1'b1);
      nop(32'h304); nop(32'h308);
      nop(32'h30c); chk("R11", "second snap", {31'd0, s_snap}, 32'd1);
      cyc(1'b1, sethi(5'd0, 22'h1), 32'h320, 1'b1);
      cyc(1'b1, BRBK, 32'h324, 1'b1);
      nop(32'h328);
      cyc(1'b1, sethi(5'd0, 22'h3), 32'h32c, 1'b1);
      chk("R7", "rollback strobe", {31'd0, s_rb}, 32'd1);
      chk("R11", "redirect to newest restart", s_redir, 32'h310);
      chk("R7", "flush front", {29'd0, s_flush}, 32'h7);
      nop(32'h310);
      chk("R7", "stays active", {31'd0, s_act}, 32'd1);
      chk("R7", "rollback one cycle", {29'd0, s_rb, s_flush[1:0]}, 32'd0);
      nop(32'h314);
      nop(32'h318);
      chk("R10", "flushed marker ignored", {31'd0, s_snap}, 32'd0);
      close_txn(32'h31c);
   endtask

   task automatic t_stall();
      cyc(1'b1, sethi(5'd0, 22'h3), 32'h400, 1'b1);
      nop(32'h404); nop(32'h408);
      cyc(1'b0, NOP, 32'h0, 1'b0); chk("R9", "stall no snap 1", {31'd0, s_snap}, 32'd0);
      cyc(1'b0, NOP, 32'h0, 1'b0); chk("R9", "stall no snap 2", {31'd0, s_snap}, 32'd0);
      nop(32'h40c); chk("R9", "snap on resume", {31'd0, s_snap}, 32'd1);
      nop(32'h410); chk("R9", "snap once", {31'd0, s_snap}, 32'd0);
      close_txn(32'h414);
   endtask

   task automatic t_forced();
      cyc(1'b1, sethi(5'd0, 22'h3), 32'h500, 1'b1);
      for (int i = 1; i <= 14; i++) begin
         if (i == 5) cyc(1'b0, NOP, 32'h0, 1'b1);
         else        nop(32'h500 + 4 * i);
         if (i == 11) chk("R8", "no commit before limit", {31'd0, s_cmt}, 32'd0);
         if (i == 12) chk("R8", "forced commit at limit", {31'd0, s_cmt}, 32'd1);
         if (i == 13) chk("R8", "inactive after forced", {31'd0, s_act}, 32'd0);
      end
   endtask

   task automatic t_rb_count();
      cyc(1'b1, sethi(5'd0, 22'h3), 32'h600, 1'b1);
      for (int i = 1; i <= 20; i++) begin
         if (i == 6)      cyc(1'b1, sethi(5'd0, 22'h1), 32'h600 + 4 * i, 1'b1);
         else if (i == 7) cyc(1'b1, BRBK, 32'h600 + 4 * i, 1'b1);
         else             nop(32'h600 + 4 * i);
         if (i == 9)  chk("R7", "rollback fires", {31'd0, s_rb}, 32'd1);
         if (i == 13) chk("R7", "count cleared by rollback", {31'd0, s_cmt}, 32'd0);
         if (i == 17) chk("R8", "no commit one early", {31'd0, s_cmt}, 32'd0);
         if (i == 18) chk("R8", "forced commit after rollback", {31'd0, s_cmt}, 32'd1);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      t_reset();
      t_ckpt_commit();
      t_ignore();
      t_rollback();
      t_stall();
      t_forced();
      t_rb_count();
      repeat (2) nop(32'h0);
      report();
   end
endmodule